// File: doc/BRIEF.md
# Floating-point compare flag generator

This block compares two IEEE 754 operands in half, single or double precision and reports the outcome as four condition flags (N, Z, C, V). It also reports an invalid-operation exception and flags an illegal format selection. One registered stage sits between the inputs and the outputs. A valid strobe travels alongside the data, so a new compare can be issued on every clock.

The second operand can be replaced by positive zero for compares against zero. A second control chooses between two invalid-operation rules. In the signaling rule, any NaN raises the exception. In the quiet rule, only a signaling NaN raises it. The result flags carry no sign of the rounding mode or trap state. Trapping and the choice of what to do with the exception belong to the surrounding logic.

Top module: `fpcmp_flags_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. When `in_valid` was low, `flags_nzcv`, `invalid_op` and `bad_fmt` keep their previous values.
- R2: `fmt_sel` selects the format: 2'b00 single (bits 31:0), 2'b01 double (bits 63:0), 2'b11 half (bits 15:0). Bits above the selected width on `op_a` and `op_b` do not affect any output.
- R3: For ordered operands, `flags_nzcv` (bit 3 = N, bit 0 = V) is 4'b1000 when A < B, 4'b0110 when A == B, and 4'b0010 when A > B.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), `flags_nzcv` is 4'b0011.
- R5: With `sig_all_nan` = 1, a quiet or signaling NaN in either operand sets `invalid_op`.
- R6: With `sig_all_nan` = 0, `invalid_op` is set only for a signaling NaN, meaning a NaN whose top fraction bit is 0. A quiet NaN leaves it clear.
- R7: With `cmp_zero` = 1, B is taken as +0 in the selected format and `op_b` has no effect on any output.
- R8: +0 and -0 compare equal in every order.
- R9: Infinities order above or below every finite value of their sign, and equal infinities compare equal.
- R10: Subnormal operands are compared exactly, without being flushed to zero.
- R11: `fmt_sel` = 2'b10 sets `bad_fmt`, forces `flags_nzcv` to 4'b0000 and keeps `invalid_op` clear, even for NaN operands.
- R12: When the parameter `HALF_EN` is 0, `fmt_sel` = 2'b11 is treated as illegal in the same way as R11.
- R13: While `rst` is high, and after it, until the first valid result, `out_valid`, `flags_nzcv`, `invalid_op` and `bad_fmt` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt_sel | input | 2 | Operand format select |
| cmp_zero | input | 1 | Compare A against +0 instead of B |
| sig_all_nan | input | 1 | Raise invalid on any NaN, not only signaling ones |
| op_a | input | 64 | First operand, right-aligned |
| op_b | input | 64 | Second operand, right-aligned |
| out_valid | output | 1 | Result registers hold a new result |
| flags_nzcv | output | 4 | Condition flags {N, Z, C, V} |
| invalid_op | output | 1 | Invalid-operation exception |
| bad_fmt | output | 1 | Format select is illegal for this build |

## Verification
The bench targets signed zeros, negative operands, subnormals, infinities, NaNs in either operand and garbage in the unused upper bus bits. Each of these has a typical failure. A plain unsigned compare would rank negative numbers backwards, and a compare on the raw bits would call +0 and -0 unequal. A design that flushes subnormals would report equality for distinct tiny values. Testing the wrong NaN bit would swap the quiet and signaling exception behaviour. The compare-with-zero path gets a NaN placed on `op_b` so that any leak of that input shows up as a flag or exception change. A second instance built without half support confirms that code 2'b11 is rejected there while the default build accepts it.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int unsigned BUS_W   = 64;
    localparam int unsigned MAG_W   = BUS_W - 1;
    localparam int unsigned NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_RSVD   = 2'b10,
        FMT_HALF   = 2'b11
    } fp_fmt_e;

    typedef enum logic [1:0] {
        ORD_LT,
        ORD_EQ,
        ORD_GT,
        ORD_UN
    } fp_ord_e;

    // Decoded operand: sign plus raw magnitude (exponent:fraction)
    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic [3:0] nzcv;
        logic       invalid;
        logic       bad_fmt;
    } cmp_res_t;

    // Width and exponent width per generate slot (0 half, 1 single, 2 double)
    function automatic int unsigned slot_width(int unsigned s);
        return (s == 0) ? 16 : (s == 1) ? 32 : 64;
    endfunction

    function automatic int unsigned slot_exp_width(int unsigned s);
        return (s == 0) ? 5 : (s == 1) ? 8 : 11;
    endfunction

    function automatic logic [3:0] ord_to_nzcv(fp_ord_e o);
        case (o)
            ORD_LT:  return 4'b1000;
            ORD_EQ:  return 4'b0110;
            ORD_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
    import fpcmp_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned EW = 8
) (
    input  logic [W-1:0] raw,
    output fp_class_t    cls
);
    localparam int unsigned FW = W - 1 - EW;

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          exp_max;
    logic          frac_nz;

    assign expo    = raw[W-2 -: EW];
    assign frac    = raw[FW-1:0];
    assign exp_max = &expo;
    assign frac_nz = |frac;

    always_comb begin
        cls      = '0;
        cls.sign = raw[W-1];
        cls.mag  = MAG_W'(raw[W-2:0]);
        cls.zero = ~|raw[W-2:0];
        cls.nan  = exp_max & frac_nz;
        cls.snan = exp_max & frac_nz & ~frac[FW-1];
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output fp_ord_e   ord
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt = a.mag < b.mag;
    assign mag_eq = a.mag == b.mag;

    always_comb begin
        if (a.nan || b.nan) begin
            ord = ORD_UN;
        end else if (a.zero && b.zero) begin
            ord = ORD_EQ;
        end else if (a.sign != b.sign) begin
            ord = a.sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            ord = ORD_EQ;
        end else if (mag_lt ^ a.sign) begin
            ord = ORD_LT;
        end else begin
            ord = ORD_GT;
        end
    end
endmodule

// File: rtl/fpcmp_flags_unit.sv
module fpcmp_flags_unit
    import fpcmp_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  fmt_sel,
    input  logic        cmp_zero,
    input  logic        sig_all_nan,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        out_valid,
    output logic [3:0]  flags_nzcv,
    output logic        invalid_op,
    output logic        bad_fmt
);
    fp_fmt_e            fmt;
    logic [BUS_W-1:0]   eff_b;
    fp_class_t          cls_a [NUM_FMT];
    fp_class_t          cls_b [NUM_FMT];
    fp_class_t          sel_a;
    fp_class_t          sel_b;
    fp_ord_e            ord;
    cmp_res_t           res_d;
    cmp_res_t           res_q;
    logic               illegal;

    assign fmt   = fp_fmt_e'(fmt_sel);
    assign eff_b = cmp_zero ? '0 : op_b;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int unsigned W  = slot_width(g);
        localparam int unsigned EW = slot_exp_width(g);

        fpcmp_unpack #(.W(W), .EW(EW)) u_unpack_a (
            .raw (op_a[W-1:0]),
            .cls (cls_a[g])
        );
        fpcmp_unpack #(.W(W), .EW(EW)) u_unpack_b (
            .raw (eff_b[W-1:0]),
            .cls (cls_b[g])
        );
    end

    always_comb begin
        case (fmt)
            FMT_HALF:   begin sel_a = cls_a[0]; sel_b = cls_b[0]; end
            FMT_DOUBLE: begin sel_a = cls_a[2]; sel_b = cls_b[2]; end
            default:    begin sel_a = cls_a[1]; sel_b = cls_b[1]; end
        endcase
    end

    fpcmp_order u_order (
        .a   (sel_a),
        .b   (sel_b),
        .ord (ord)
    );

    assign illegal = (fmt == FMT_RSVD) || ((fmt == FMT_HALF) && !HALF_EN);

    always_comb begin
        res_d = '0;
        if (illegal) begin
            res_d.bad_fmt = 1'b1;
        end else begin
            res_d.nzcv    = ord_to_nzcv(ord);
            res_d.invalid = sig_all_nan ? (sel_a.nan | sel_b.nan)
                                        : (sel_a.snan | sel_b.snan);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign flags_nzcv = res_q.nzcv;
    assign invalid_op = res_q.invalid;
    assign bad_fmt    = res_q.bad_fmt;
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  fmt_sel,
    input logic        cmp_zero,
    input logic        sig_all_nan,
    input logic [63:0] op_a,
    input logic        out_valid,
    input logic [3:0]  flags_nzcv,
    input logic        invalid_op,
    input logic        bad_fmt
);
    logic a_sp_nan;
    logic a_dp_qnan;

    assign a_sp_nan  = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
    assign a_dp_qnan = (op_a[62:52] == 11'h7FF) && op_a[51];

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(flags_nzcv)
                       && $stable(invalid_op) && $stable(bad_fmt)));

    assert_flag_codes_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !bad_fmt) |-> (flags_nzcv == 4'b1000 || flags_nzcv == 4'b0110
                                     || flags_nzcv == 4'b0010 || flags_nzcv == 4'b0011));

    assert_unordered_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_sel == 2'b00 && a_sp_nan) |=> (flags_nzcv == 4'b0011));

    assert_any_nan_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sig_all_nan && fmt_sel == 2'b00 && a_sp_nan) |=> invalid_op);

    assert_quiet_nan_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !sig_all_nan && cmp_zero && fmt_sel == 2'b01 && a_dp_qnan)
        |=> !invalid_op);

    assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_sel == 2'b10) |=> (bad_fmt && flags_nzcv == 4'b0000 && !invalid_op));
endmodule

bind fpcmp_flags_unit fpcmp_flags_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .fmt_sel     (fmt_sel),
    .cmp_zero    (cmp_zero),
    .sig_all_nan (sig_all_nan),
    .op_a        (op_a),
    .out_valid   (out_valid),
    .flags_nzcv  (flags_nzcv),
    .invalid_op  (invalid_op),
    .bad_fmt     (bad_fmt)
);

// File: tb/fpcmp_flags_unit_bench.sv
module fpcmp_flags_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  fmt_sel;
    logic        cmp_zero;
    logic        sig_all_nan;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic        ov_h, ov_n;
    logic [3:0]  fl_h, fl_n;
    logic        inv_h, inv_n;
    logic        bad_h, bad_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [6:0] last_h, last_n;

    always #4 clk = ~clk;

    fpcmp_flags_unit u_fpcmp_flags_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .cmp_zero(cmp_zero), .sig_all_nan(sig_all_nan), .op_a(op_a), .op_b(op_b),
        .out_valid(ov_h), .flags_nzcv(fl_h), .invalid_op(inv_h), .bad_fmt(bad_h)
    );

    fpcmp_flags_unit #(.HALF_EN(1'b0)) u_fpcmp_flags_unit_nohalf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .cmp_zero(cmp_zero), .sig_all_nan(sig_all_nan), .op_a(op_a), .op_b(op_b),
        .out_valid(ov_n), .flags_nzcv(fl_n), .invalid_op(inv_n), .bad_fmt(bad_n)
    );

    // Behavioural model: signed ordering key, NaN tests on extracted fields
    function automatic void decode(input logic [63:0] v, input int w, input int ew,
                                   output longint key, output logic nan, output logic snan);
        logic [63:0] mag, fr, ex;
        int fw;
        fw   = w - 1 - ew;
        mag  = v & ((64'd1 << (w - 1)) - 64'd1);
        ex   = mag >> fw;
        fr   = mag & ((64'd1 << fw) - 64'd1);
        nan  = (ex == ((64'd1 << ew) - 64'd1)) && (fr != 0);
        snan = nan && !fr[fw-1];
        key  = v[w-1] ? -longint'(mag) : longint'(mag);
    endfunction

    function automatic logic [5:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] f,
                                         logic cz, logic sa, logic half_ok);
        int w, ew;
        logic [63:0] mask;
        longint ka, kb;
        logic na, nb, sna, snb, inv;
        logic [3:0] fl;
        if (f == 2'b10 || (f == 2'b11 && !half_ok)) return 6'b0000_0_1;
        w  = (f == 2'b00) ? 32 : (f == 2'b01) ? 64 : 16;
        ew = (f == 2'b00) ? 8  : (f == 2'b01) ? 11 : 5;
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        a = a & mask;
        b = cz ? 64'd0 : (b & mask);
        decode(a, w, ew, ka, na, sna);
        decode(b, w, ew, kb, nb, snb);
        if (na || nb)      fl = 4'b0011;
        else if (ka < kb)  fl = 4'b1000;
        else if (ka == kb) fl = 4'b0110;
        else               fl = 4'b0010;
        inv = sa ? (na | nb) : (sna | snb);
        return {fl, inv, 1'b0};
    endfunction

    task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual={v,nzcv,inv,bad}=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic run(logic [63:0] a, logic [63:0] b, logic [1:0] f,
                       logic cz, logic sa, string tag);
        logic [5:0] eh, en;
        in_valid = 1'b1; op_a = a; op_b = b; fmt_sel = f; cmp_zero = cz; sig_all_nan = sa;
        eh = model(a, b, f, cz, sa, 1'b1);
        en = model(a, b, f, cz, sa, 1'b0);
        @(negedge clk);
        last_h = {1'b1, eh};
        last_n = {1'b1, en};
        chk(tag, {ov_h, fl_h, inv_h, bad_h}, last_h);
        chk({tag, " (no-half build, R12)"}, {ov_n, fl_n, inv_n, bad_n}, last_n);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; fmt_sel = 2'b00; cmp_zero = 1'b0;
        sig_all_nan = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        chk("R13 reset", {ov_h, fl_h, inv_h, bad_h}, 7'b0);
        chk("R13 reset no-half", {ov_n, fl_n, inv_n, bad_n}, 7'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 idle after reset", {ov_h, fl_h, inv_h, bad_h}, 7'b0);

        // R3 ordered outcomes
        run(64'h3F800000, 64'h40000000, 2'b00, 0, 0, "R3 sp 1<2");
        run(64'h40000000, 64'h3F800000, 2'b00, 0, 0, "R3 sp 2>1");
        run(64'h3F800000, 64'h3F800000, 2'b00, 0, 0, "R3 sp eq");
        run(64'hBF800000, 64'h3F800000, 2'b00, 0, 0, "R3 sp -1<1");
        run(64'hC0000000, 64'hBF800000, 2'b00, 0, 0, "R3 sp -2<-1");
        run(64'h3FF0000000000000, 64'h4000000000000000, 2'b01, 0, 0, "R3 dp 1<2");
        // R8 signed zeros
        run(64'h00000000, 64'h80000000, 2'b00, 0, 0, "R8 sp +0 vs -0");
        run(64'h8000000000000000, 64'h0, 2'b01, 0, 0, "R8 dp -0 vs +0");
        // R9 infinities
        run(64'h7F800000, 64'h7F7FFFFF, 2'b00, 0, 0, "R9 +inf > max");
        run(64'hFF800000, 64'hFF7FFFFF, 2'b00, 0, 0, "R9 -inf < -max");
        run(64'h7F800000, 64'h7F800000, 2'b00, 0, 0, "R9 inf == inf");
        // R10 subnormals
        run(64'h00000001, 64'h00000002, 2'b00, 0, 0, "R10 sp tiny order");
        run(64'h80000001, 64'h00000000, 2'b00, 0, 0, "R10 -sub < +0");
        run(64'h8000000000000001, 64'h8000000000000002, 2'b01, 0, 0, "R10 dp neg subs");
        // R4/R5/R6 NaNs
        run(64'h7FC00000, 64'h3F800000, 2'b00, 0, 0, "R4 R6 sp qnan quiet");
        run(64'h7F800001, 64'h3F800000, 2'b00, 0, 0, "R6 sp snan quiet");
        run(64'h7FC00000, 64'h3F800000, 2'b00, 0, 1, "R5 sp qnan signaling");
        run(64'h3FF0000000000000, 64'h7FF8000000000000, 2'b01, 0, 1, "R5 dp qnan in B");
        run(64'h3FF0000000000000, 64'h7FF0000000000001, 2'b01, 0, 0, "R6 dp snan in B");
        // R2 format lanes and upper bits
        run(64'hDEADBEEF_3F800000, 64'h12345678_40000000, 2'b00, 0, 0, "R2 sp upper ignored");
        run(64'hFFFFFFFF_FFFF3C00, 64'h00000000_7FFF4000, 2'b11, 0, 0, "R2 hp 1<2");
        run(64'h0000_0000_0000_7C01, 64'h3C00, 2'b11, 0, 0, "R2 R6 hp snan");
        run(64'h7C00, 64'hFC00, 2'b11, 0, 0, "R2 R9 hp inf order");
        // R7 compare with zero
        run(64'h3F800000, 64'h7FC00000, 2'b00, 1, 1, "R7 zero cmp, nan on B ignored");
        run(64'h80000000, 64'hBF800000, 2'b00, 1, 0, "R7 R8 -0 vs zero");
        run(64'h8000000000000001, 64'h7FF0000000000001, 2'b01, 1, 0, "R7 dp -sub vs zero");
        run(64'h7E00, 64'h7C01, 2'b11, 1, 0, "R7 hp qnan vs zero");
        // R11 reserved format
        run(64'h7F800001, 64'h7F800001, 2'b10, 0, 1, "R11 reserved fmt");
        run(64'h3F800000, 64'h40000000, 2'b00, 0, 0, "R11 recovery");

        // R1 idle cycles hold previous result
        in_valid = 1'b0; op_a = 64'h7F800001; op_b = 64'h0; fmt_sel = 2'b10; sig_all_nan = 1'b1;
        @(negedge clk);
        chk("R1 idle hold", {ov_h, fl_h, inv_h, bad_h}, {1'b0, last_h[5:0]});
        @(negedge clk);
        chk("R1 idle hold 2", {ov_n, fl_n, inv_n, bad_n}, {1'b0, last_n[5:0]});
        run(64'hBF800000, 64'hBF800000, 2'b00, 0, 0, "R1 R3 resume");
        summary();
    end
endmodule